// File: doc/BRIEF.md
# CDR Lock Qualification Monitor

This block judges whether a clock-and-data-recovery loop has reached and kept frequency lock. On every check strobe it takes the signed frequency error, in ppm counts, and compares its magnitude with a programmable tolerance. A two-bit mode can enlarge that tolerance. Lock is taken on one passing check. Once lock is held, failing checks are counted, and lock is given up only after a programmable number of them in a row. A passing check clears the count.

The block also keeps a copy of the frequency error for software. The copy either follows every check or is taken only on request, and a ready flag shows when it is valid. A separate timer watches signal detect. When signal detect has stayed low for a fixed number of clock cycles, the timer requests power-down of everything except the detector. A disable input suppresses that request.

Top module: `cdr_lock_qual`

## Requirements
- R1: The effective tolerance depends on `tol_mode_i`. Mode 0 uses the 8-bit base as it is. Mode 1 uses base plus base[3:1]. Mode 2 uses twice the base. Mode 3 uses twice the base plus base[3:1]. The result is held in 10 bits, so it never overflows.
- R2: While unlocked, a check with `sig_det_i` high and |`ppm_err_i`| at or below the effective tolerance sets `lock_o` in the next cycle. A check with a larger magnitude leaves `lock_o` low.
- R3: While locked, with retry setting N in `retry_n_i` (0 to 3), the first N consecutive failing checks leave `lock_o` high. The (N+1)-th consecutive failing check clears `lock_o` in the next cycle.
- R4: While locked, a passing check returns the failure count to zero. The next loss of lock then needs N+1 new consecutive failing checks.
- R5: When `sig_det_i` is sampled low, `lock_o` is low in the next cycle and the failure count is cleared.
- R6: With `err_manual_i` low, every check copies `ppm_err_i` into `err_val_o` and sets `err_rdy_o` in the next cycle. Without a check, `err_val_o` holds its value.
- R7: With `err_manual_i` high, a check copies the error only while a request is pending. A one-cycle `err_grab_i` pulse raises `err_busy_o` and lowers `err_rdy_o`. The first check after that copies the error, sets `err_rdy_o` and clears `err_busy_o`. Checks made with no request pending leave `err_val_o` unchanged.
- R8: After `sig_det_i` has been sampled low on IDLE_CYC consecutive clock edges, `pwr_down_o` is high. It drops in the same cycle that `sig_det_i` goes high, and the timer then starts again from zero.
- R9: While `lp_disable_i` is high, `pwr_down_o` stays low. The idle timer keeps counting underneath.
- R10: After reset, `lock_o`, `err_rdy_o`, `err_busy_o` and `pwr_down_o` are low and `err_val_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| check_i | input | 1 | One-cycle strobe marking a lock check |
| ppm_err_i | input | ERR_W | Signed frequency error in ppm counts |
| sig_det_i | input | 1 | Signal detect from the receiver |
| tol_base_i | input | 8 | Base frequency tolerance |
| tol_mode_i | input | 2 | Tolerance scaling mode |
| retry_n_i | input | 2 | Failing checks tolerated before lock is dropped |
| lp_disable_i | input | 1 | Suppresses the power-down request |
| err_manual_i | input | 1 | 1: copy the error only on request |
| err_grab_i | input | 1 | One-cycle request to copy the error |
| lock_o | output | 1 | Lock flag |
| err_rdy_o | output | 1 | Copied error value is valid |
| err_busy_o | output | 1 | A copy request is pending |
| err_val_o | output | ERR_W | Copied signed frequency error |
| pwr_down_o | output | 1 | Power-down request after a long signal loss |

## Verification
The bench builds the block with ERR_W = 11 and IDLE_CYC = 20. An error range of -1024 to 1023 covers the largest scaled tolerance, 517, on both sides of the boundary. This makes a full sweep possible: every base value in every mode, with errors one below, at and one above the tolerance, in both signs. The short idle window lets the bench check the power-down request exactly at its threshold edge, check that it clears at once, and check its disable, all within a short run. Every retry setting is tried both for a plain loss of lock and for a count that recovers partway.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;
  localparam int unsigned TOL_BASE_W = 8;
  localparam int unsigned TOL_W      = 10;
  localparam int unsigned RETRY_W    = 2;

  typedef enum logic [1:0] {
    TOL_X1      = 2'd0,
    TOL_X1_FRAC = 2'd1,
    TOL_X2      = 2'd2,
    TOL_X2_FRAC = 2'd3
  } tol_mode_e;
endpackage

// File: rtl/clq_tol_scale.sv
module clq_tol_scale
  import cdr_lock_pkg::*;
(
  input  logic [TOL_BASE_W-1:0] base_i,
  input  tol_mode_e             mode_i,
  output logic [TOL_W-1:0]      tol_o
);
  logic [TOL_W-1:0] one_x, two_x, frac;

  assign one_x = TOL_W'(base_i);
  assign two_x = TOL_W'({base_i, 1'b0});
  assign frac  = TOL_W'(base_i[3:1]);

  always_comb begin
    unique case (mode_i)
      TOL_X1:      tol_o = one_x;
      TOL_X1_FRAC: tol_o = one_x + frac;
      TOL_X2:      tol_o = two_x;
      default:     tol_o = two_x + frac;
    endcase
  end

  // R1: scaled value never falls below base nor exceeds 2*base+7
  always_comb begin
    a_r1_tol_bounds: assert (tol_o >= one_x && tol_o <= two_x + TOL_W'(7));
  end
endmodule

// File: rtl/clq_lock_fsm.sv
module clq_lock_fsm
  import cdr_lock_pkg::*;
#(
  parameter int unsigned ERR_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    check_i,
  input  logic                    sig_det_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic [TOL_W-1:0]        tol_i,
  input  logic [RETRY_W-1:0]      retry_i,
  output logic                    lock_o
);
  localparam int unsigned CMP_W = (ERR_W > TOL_W) ? ERR_W : TOL_W;

  logic [ERR_W-1:0]   mag;
  logic               pass;
  logic               lock_q;
  logic [RETRY_W-1:0] fail_q;

  // magnitude of the most negative code still fits unsigned in ERR_W bits
  assign mag  = err_i[ERR_W-1] ? (~err_i + ERR_W'(1)) : err_i;
  assign pass = CMP_W'(mag) <= CMP_W'(tol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      fail_q <= '0;
    end else if (!sig_det_i) begin
      lock_q <= 1'b0;
      fail_q <= '0;
    end else if (check_i) begin
      if (!lock_q) begin
        lock_q <= pass;
        fail_q <= '0;
      end else if (pass) begin
        fail_q <= '0;
      end else if (fail_q == retry_i) begin
        lock_q <= 1'b0;
        fail_q <= '0;
      end else begin
        fail_q <= fail_q + RETRY_W'(1);
      end
    end
  end

  assign lock_o = lock_q;

  a_r5_sig_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_det_i |=> !lock_q);
  a_r2_rise_on_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(check_i && sig_det_i));
  a_r3_drop_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> ($past(check_i) || !$past(sig_det_i)));
endmodule

// File: rtl/clq_err_capture.sv
module clq_err_capture #(
  parameter int unsigned ERR_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    check_i,
  input  logic                    manual_i,
  input  logic                    grab_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic signed [ERR_W-1:0] val_o,
  output logic                    rdy_o,
  output logic                    busy_o
);
  logic signed [ERR_W-1:0] val_q;
  logic                    rdy_q, busy_q, cap;

  assign cap = check_i && (!manual_i || busy_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      rdy_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (cap) begin
        val_q  <= err_i;
        rdy_q  <= 1'b1;
        busy_q <= 1'b0;
      end
      // a fresh request overrides a completing one
      if (grab_i) begin
        rdy_q  <= 1'b0;
        busy_q <= 1'b1;
      end
    end
  end

  assign val_o  = val_q;
  assign rdy_o  = rdy_q;
  assign busy_o = busy_q;

  a_r6_val_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_i |=> $stable(val_q));
  a_r7_busy_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && check_i && !grab_i) |=> (!busy_q && rdy_q));
endmodule

// File: rtl/clq_idle_timer.sv
module clq_idle_timer #(
  parameter int unsigned IDLE_CYC = 12_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_det_i,
  input  logic disable_i,
  output logic pd_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             expired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (sig_det_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT)    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expired = (cnt_q == LIMIT);
  // drop at once when the signal returns
  assign pd_o    = expired && !sig_det_i && !disable_i;

  a_r8_pd_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> !$past(sig_det_i));
endmodule

// File: rtl/cdr_lock_qual.sv
module cdr_lock_qual
  import cdr_lock_pkg::*;
#(
  parameter int unsigned ERR_W    = 12,
  parameter int unsigned IDLE_CYC = 12_500_000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    check_i,
  input  logic signed [ERR_W-1:0] ppm_err_i,
  input  logic                    sig_det_i,
  input  logic [7:0]              tol_base_i,
  input  logic [1:0]              tol_mode_i,
  input  logic [1:0]              retry_n_i,
  input  logic                    lp_disable_i,
  input  logic                    err_manual_i,
  input  logic                    err_grab_i,
  output logic                    lock_o,
  output logic                    err_rdy_o,
  output logic                    err_busy_o,
  output logic signed [ERR_W-1:0] err_val_o,
  output logic                    pwr_down_o
);
  logic [TOL_W-1:0] tol;

  clq_tol_scale u_tol (
    .base_i (tol_base_i),
    .mode_i (tol_mode_e'(tol_mode_i)),
    .tol_o  (tol)
  );

  clq_lock_fsm #(.ERR_W(ERR_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .check_i   (check_i),
    .sig_det_i (sig_det_i),
    .err_i     (ppm_err_i),
    .tol_i     (tol),
    .retry_i   (retry_n_i),
    .lock_o    (lock_o)
  );

  clq_err_capture #(.ERR_W(ERR_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .check_i  (check_i),
    .manual_i (err_manual_i),
    .grab_i   (err_grab_i),
    .err_i    (ppm_err_i),
    .val_o    (err_val_o),
    .rdy_o    (err_rdy_o),
    .busy_o   (err_busy_o)
  );

  clq_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sig_det_i (sig_det_i),
    .disable_i (lp_disable_i),
    .pd_o      (pwr_down_o)
  );
endmodule

// File: tb/tb_cdr_lock_qual.sv
`timescale 1ns/1ps
module tb_cdr_lock_qual;
  localparam int ERR_W = 11;
  localparam int IDLE  = 20;

  logic clk = 0, rst_n = 0;
  logic check = 0, sig_det = 1, lp_dis = 0, manual = 0, grab = 0;
  logic signed [ERR_W-1:0] ppm = '0;
  logic [7:0] base = '0;
  logic [1:0] mode = '0, retry = '0;
  logic lock, rdy, busy, pd;
  logic signed [ERR_W-1:0] val;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cdr_lock_qual #(.ERR_W(ERR_W), .IDLE_CYC(IDLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .check_i(check), .ppm_err_i(ppm),
    .sig_det_i(sig_det), .tol_base_i(base), .tol_mode_i(mode),
    .retry_n_i(retry), .lp_disable_i(lp_dis), .err_manual_i(manual),
    .err_grab_i(grab), .lock_o(lock), .err_rdy_o(rdy), .err_busy_o(busy),
    .err_val_o(val), .pwr_down_o(pd)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_check(int e);
    @(negedge clk); ppm = ERR_W'(e); check = 1;
    @(negedge clk); check = 0;
  endtask

  task automatic clear_lock();
    @(negedge clk); sig_det = 0;
    @(negedge clk); sig_det = 1;
  endtask

  function automatic int tol_of(int b, int m);
    int t = (m >= 2) ? b * 2 : b;
    if (m % 2 == 1) t += (b / 2) % 8;
    return t;
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 lock", lock, 0); chk("R10 rdy", rdy, 0); chk("R10 busy", busy, 0);
    chk("R10 val", val, 0);   chk("R10 pd", pd, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 / R2 sweep: every base, every mode, boundary +-1, both signs
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 256; b++) begin
        for (int off = -1; off <= 1; off++) begin
          for (int s = 0; s < 2; s++) begin
            int t = tol_of(b, m);
            int mag = t + off;
            if (mag < 0) continue;
            mode = 2'(m); base = 8'(b);
            clear_lock();
            do_check(s ? -mag : mag);
            chk("R1/R2 acquire", lock, (mag <= t) ? 1 : 0);
          end
        end
      end
    end

    // R3 retry count for every N
    mode = 0; base = 8'd10;
    for (int n = 0; n < 4; n++) begin
      retry = 2'(n);
      clear_lock();
      do_check(3);
      chk("R3 locked", lock, 1);
      for (int k = 1; k <= n + 1; k++) begin
        do_check(-50);
        chk("R3 fail filter", lock, (k <= n) ? 1 : 0);
      end
    end

    // R4 pass mid-sequence clears the count
    for (int n = 1; n < 4; n++) begin
      retry = 2'(n);
      clear_lock();
      do_check(0);
      for (int k = 0; k < n; k++) do_check(40);
      do_check(-10);
      chk("R4 pass keeps lock", lock, 1);
      for (int k = 0; k < n; k++) do_check(40);
      chk("R4 count restarted", lock, 1);
      do_check(40);
      chk("R4 drop after N+1", lock, 0);
    end

    // R5 signal loss
    retry = 3;
    clear_lock();
    do_check(0);
    do_check(99);
    @(negedge clk); sig_det = 0;
    @(negedge clk);
    chk("R5 lock low", lock, 0);
    sig_det = 1;
    do_check(99);
    chk("R5 no lock on bad", lock, 0);

    // R6 auto capture
    manual = 0;
    do_check(-37);
    chk("R6 val", val, -37); chk("R6 rdy", rdy, 1);
    @(negedge clk); ppm = 11'sd200;
    @(negedge clk);
    chk("R6 hold", val, -37);

    // R7 manual capture
    manual = 1;
    do_check(100);
    chk("R7 no capture", val, -37);
    @(negedge clk); grab = 1;
    @(negedge clk); grab = 0;
    chk("R7 busy", busy, 1); chk("R7 rdy cleared", rdy, 0);
    do_check(55);
    chk("R7 val", val, 55); chk("R7 rdy", rdy, 1); chk("R7 busy clear", busy, 0);
    do_check(-1);
    chk("R7 one shot", val, 55);

    // R8 power-down timing
    lp_dis = 0;
    @(negedge clk); sig_det = 0;
    repeat (IDLE - 1) @(negedge clk);
    chk("R8 before limit", pd, 0);
    @(negedge clk);
    chk("R8 at limit", pd, 1);
    sig_det = 1; #1;
    chk("R8 immediate clear", pd, 0);
    @(negedge clk); sig_det = 0;
    repeat (IDLE - 1) @(negedge clk);
    chk("R8 restarted", pd, 0);

    // R9 disable
    lp_dis = 1;
    repeat (10) @(negedge clk);
    chk("R9 suppressed", pd, 0);
    lp_dis = 0; #1;
    chk("R9 timer kept counting", pd, 1);
    sig_det = 1;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule